// File: doc/BRIEF.md
# Threshold-Interrupt Stream FIFO Slave

This block buffers a slow stream of 36-bit words in a 512-entry first-in first-out store and presents them to a memory-mapped bus as a read slave. The producer pushes words with a write enable. A DMA master drains the store over the bus. When the number of stored words reaches a programmable threshold, an interrupt line rises. Software can then hand the drain to a DMA engine, which reads the data address on consecutive cycles and receives one word per clock.

The head word is always visible at the storage output. A bus read of the data address therefore needs no wait state. Read data appears in the cycle after the request, with a fixed latency of one. The entry is removed at the end of that data cycle. This is driven by a registered copy of the qualified read request, so a stream of back-to-back requests pops one entry per clock. A small register window beside the data address shows the fill level and a sticky overflow flag, and holds the interrupt threshold.

Top module: `thr_fifo_slave`

## Requirements
- R1: After reset the fill level is 0, the overflow flag is 0, the threshold is 480, `irq_o` is low and `rdata_o` is 0.
- R2: A read of address 0 returns, in the next cycle, the low 32 bits of the oldest stored word; bits 35..32 are not visible. The word is removed at the end of that data cycle.
- R3: Read requests to address 0 on consecutive cycles return consecutive stored words in push order, one per clock, and lower the level by one per request.
- R4: A read of address 1 returns the fill level in bits 9..0 and the overflow flag in bit 31, with all other bits zero. Reads of addresses 1, 2 and 3 never remove a word.
- R5: A bus write to address 2 loads bits 9..0 of `wdata_i` into the threshold, and a read of address 2 returns it zero-extended. Bus writes to addresses 0, 1 and 3 change nothing.
- R6: `irq_o` is high exactly while the fill level is greater than or equal to the threshold. It follows a push or a threshold write in the cycle after the edge that applies it, and falls once the level drops below the threshold.
- R7: At 512 stored words a push is dropped, the stored contents are kept, and the overflow flag is set. The flag stays set until reset.
- R8: A read of address 0 while the store is empty returns 0 and leaves the level and read order unchanged.
- R9: A push and a pop in the same cycle leave the level unchanged and keep the order.
- R10: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 36 | Stream word to store |
| wr_en_i | input | 1 | Push `wr_data_i` this cycle |
| cs_i | input | 1 | Bus chip select |
| rd_i | input | 1 | Bus read strobe |
| wr_i | input | 1 | Bus write strobe |
| addr_i | input | 2 | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, valid in the cycle after the request |
| irq_o | output | 1 | Level reached threshold |

## Verification
If the read pointer or level counter goes wrong, the port side shows it at once. The very next data read returns a word out of push order, or the status read one cycle after a pop shows a level that differs from the count of pushes minus pops. The threshold compare is checked at its edge, with the level one below and exactly at the threshold, so an off-by-one shows up as `irq_o` one push early or late. A pop that was never qualified, or a push that was not dropped at full, appears in the drain that follows as a missing, repeated or extra word.

// File: rtl/thr_fifo_pkg.sv
package thr_fifo_pkg;
  // word address decode of the slave window
  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_STAT = 2'd1,
    SEL_THR  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned ADDR_W = 2;
endpackage

// File: rtl/thr_fifo_store.sv
module thr_fifo_store #(
  parameter int unsigned DATA_W = 36,
  parameter int unsigned DEPTH  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= data_i;
  end

  // show-ahead: head is read without a pop
  assign head_o = mem_q[rd_ptr_q];
endmodule

// File: rtl/thr_fifo_level.sv
module thr_fifo_level #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LVL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_req_i,
  input  logic             pop_req_i,
  input  logic [LVL_W-1:0] thr_i,
  output logic             push_ok_o,
  output logic             pop_ok_o,
  output logic             empty_o,
  output logic [LVL_W-1:0] level_o,
  output logic             ovf_o,
  output logic             irq_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] level_q;
  logic             ovf_q;
  logic             full;

  assign full      = (level_q == FULL_LVL);
  assign empty_o   = (level_q == '0);
  assign push_ok_o = push_req_i & ~full;
  assign pop_ok_o  = pop_req_i & ~empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      unique case ({push_ok_o, pop_ok_o})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (push_req_i && full) ovf_q <= 1'b1;
    end
  end

  assign level_o = level_q;
  assign ovf_o   = ovf_q;
  assign irq_o   = (level_q >= thr_i);
endmodule

// File: rtl/thr_fifo_port.sv
module thr_fifo_port
  import thr_fifo_pkg::*;
#(
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned LVL_W   = 10,
  parameter int unsigned THR_RST = 480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              empty_i,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              ovf_i,
  output logic              pop_req_o,
  output logic [LVL_W-1:0]  thr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  reg_sel_e         sel_q;
  logic             rd_q;
  logic [LVL_W-1:0] thr_q;
  logic [BUS_W-1:0] head_bus;
  reg_sel_e         sel_in;
  logic             unused_wdata;

  assign sel_in       = reg_sel_e'(addr_i);
  assign unused_wdata = ^wdata_i[BUS_W-1:LVL_W];

  generate
    if (DATA_W > BUS_W) begin : g_trunc
      logic unused_head;
      assign unused_head = ^head_i[DATA_W-1:BUS_W];
      assign head_bus    = head_i[BUS_W-1:0];
    end else if (DATA_W == BUS_W) begin : g_same
      assign head_bus = head_i;
    end else begin : g_ext
      assign head_bus = BUS_W'(head_i);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= 1'b0;
      sel_q <= SEL_NONE;
      thr_q <= LVL_W'(THR_RST);
    end else begin
      rd_q  <= cs_i & rd_i;
      sel_q <= sel_in;
      if (cs_i && wr_i && sel_in == SEL_THR) thr_q <= wdata_i[LVL_W-1:0];
    end
  end

  // registered cs&rd on the data address: pops at end of the data cycle
  assign pop_req_o = rd_q && (sel_q == SEL_DATA);
  assign thr_o     = thr_q;

  always_comb begin
    rdata_o = '0;
    if (rd_q) begin
      unique case (sel_q)
        SEL_DATA: if (!empty_i) rdata_o = head_bus;
        SEL_STAT: begin
          rdata_o[BUS_W-1]   = ovf_i;
          rdata_o[LVL_W-1:0] = level_i;
        end
        SEL_THR:  rdata_o[LVL_W-1:0] = thr_q;
        default:  rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/thr_fifo_slave.sv
module thr_fifo_slave
  import thr_fifo_pkg::*;
#(
  parameter int unsigned DATA_W  = 36,
  parameter int unsigned BUS_W   = 32,
  parameter int unsigned DEPTH   = 512,
  parameter int unsigned THR_RST = 480
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_en_i,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_o
);
  localparam int unsigned LVL_W = $clog2(DEPTH) + 1;

  logic              push_ok, pop_ok, pop_req, empty, ovf;
  logic [LVL_W-1:0]  level_w, thr_w;
  logic [DATA_W-1:0] head;

  thr_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_ok),
    .pop_i  (pop_ok),
    .data_i (wr_data_i),
    .head_o (head)
  );

  thr_fifo_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_req_i (wr_en_i),
    .pop_req_i  (pop_req),
    .thr_i      (thr_w),
    .push_ok_o  (push_ok),
    .pop_ok_o   (pop_ok),
    .empty_o    (empty),
    .level_o    (level_w),
    .ovf_o      (ovf),
    .irq_o      (irq_o)
  );

  thr_fifo_port #(
    .BUS_W(BUS_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .THR_RST(THR_RST)
  ) u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_i      (cs_i),
    .rd_i      (rd_i),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .head_i    (head),
    .empty_i   (empty),
    .level_i   (level_w),
    .ovf_i     (ovf),
    .pop_req_o (pop_req),
    .thr_o     (thr_w),
    .rdata_o   (rdata_o)
  );
endmodule

// File: rtl/thr_fifo_chk.sv
module thr_fifo_chk #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LVL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             cs_i,
  input logic             rd_i,
  input logic             wr_i,
  input logic [1:0]       addr_i,
  input logic [LVL_W-1:0] level_i,
  input logic             pop_req_i,
  input logic             ovf_i,
  input logic             irq_i
);
  // R7
  lvl_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i <= LVL_W'(DEPTH));

  // R7
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> ovf_i);

  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && level_i == '0 && !wr_en_i) |=> level_i == '0);

  // R9
  push_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_req_i && wr_en_i && level_i != '0 && level_i != LVL_W'(DEPTH))
      |=> $stable(level_i));

  // R4
  stat_nopop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i != 2'd0) |=> !pop_req_i);

  // R3
  lvl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i == $past(level_i)) || (level_i == $past(level_i) + 1'b1)
      || (level_i + 1'b1 == $past(level_i)));

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> ($past(wr_en_i) || $past(cs_i && wr_i)));
endmodule

bind thr_fifo_slave thr_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .cs_i      (cs_i),
  .rd_i      (rd_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .level_i   (level_w),
  .pop_req_i (pop_req),
  .ovf_i     (ovf),
  .irq_i     (irq_o)
);

// File: tb/tb_thr_fifo_slave.sv
`timescale 1ns/1ps
module tb_thr_fifo_slave;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [35:0] wr_data_i = '0;
  logic        wr_en_i = 1'b0;
  logic        cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  thr_fifo_slave dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_data_i(wr_data_i), .wr_en_i(wr_en_i),
    .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o)
  );

  function automatic logic [35:0] wv(int i);
    return {4'(i) ^ 4'h5, 32'hC0DE_0000 + 32'(i)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(int i);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = wv(i);
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    cs_i = 1'b0; rd_i = 1'b0;
    @(negedge clk_i);
    d = rdata_o;
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  // back-to-back data reads; returns mismatch count
  task automatic burst(int n, int first, output int errs);
    errs = 0;
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = 2'd0;
    for (int k = 0; k < n; k++) begin
      @(posedge clk_i); #1;
      if (k == n - 1) begin cs_i = 1'b0; rd_i = 1'b0; end
      @(negedge clk_i);
      if (rdata_o !== wv(first + k)[31:0]) errs++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk_i);
    check("R1 irq in reset", {31'b0, irq_o}, 32'd0);
    check("R1 rdata in reset", rdata_o, 32'd0);
    @(posedge clk_i); #1 rst_ni = 1'b1;
    bus_read(2'd1, d); check("R1 status", d, 32'd0);
    bus_read(2'd2, d); check("R1 threshold", d, 32'd480);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    int e;
    for (int i = 0; i < 4; i++) push(i);
    bus_read(2'd0, d); check("R2 head word", d, wv(0)[31:0]);
    bus_read(2'd1, d); check("R4 level after pop", d, 32'd3);
    bus_read(2'd1, d); check("R4 status read no pop", d, 32'd3);
    bus_read(2'd3, d); check("R10 addr3 zero", d, 32'd0);
    bus_read(2'd2, d);
    bus_read(2'd1, d); check("R4 level kept", d, 32'd3);
    burst(3, 1, e); check("R3 burst order", 32'(e), 32'd0);
    bus_read(2'd1, d); check("R3 level after burst", d, 32'd0);
  endtask

  task automatic t_empty;
    logic [31:0] d;
    bus_read(2'd0, d); check("R8 empty read zero", d, 32'd0);
    bus_read(2'd1, d); check("R8 level unchanged", d, 32'd0);
    push(50);
    bus_read(2'd0, d); check("R8 order after empty read", d, wv(50)[31:0]);
  endtask

  task automatic t_thr;
    logic [31:0] d;
    int e;
    bus_write(2'd2, 32'hFFFF_FC03);
    bus_read(2'd2, d); check("R5 threshold readback", d, 32'd3);
    bus_write(2'd0, 32'd7); bus_write(2'd1, 32'd7); bus_write(2'd3, 32'd7);
    bus_read(2'd2, d); check("R5 other writes ignored thr", d, 32'd3);
    bus_read(2'd1, d); check("R5 other writes ignored lvl", d, 32'd0);
    push(100); push(101);
    @(negedge clk_i); check("R6 irq below thr", {31'b0, irq_o}, 32'd0);
    push(102);
    @(negedge clk_i); check("R6 irq at thr", {31'b0, irq_o}, 32'd1);
    bus_read(2'd0, d); check("R2 thr head", d, wv(100)[31:0]);
    @(negedge clk_i); check("R6 irq falls", {31'b0, irq_o}, 32'd0);
    bus_write(2'd2, 32'd2);
    @(negedge clk_i); check("R6 irq on thr write", {31'b0, irq_o}, 32'd1);
    burst(2, 101, e); check("R3 thr drain", 32'(e), 32'd0);
    bus_write(2'd2, 32'd480);
  endtask

  task automatic t_full;
    logic [31:0] d;
    int e;
    for (int i = 0; i < 479; i++) push(1000 + i);
    @(negedge clk_i); check("R6 irq at 479", {31'b0, irq_o}, 32'd0);
    push(1479);
    @(negedge clk_i); check("R6 irq at 480", {31'b0, irq_o}, 32'd1);
    for (int i = 480; i < 512; i++) push(1000 + i);
    bus_read(2'd1, d); check("R7 full level", d, 32'd512);
    push(7777);
    bus_read(2'd1, d); check("R7 overflow flag", d, 32'h8000_0200);
    burst(512, 1000, e); check("R7 drain keeps contents", 32'(e), 32'd0);
    bus_read(2'd1, d); check("R7 overflow sticky", d, 32'h8000_0000);
    check("R6 irq after drain", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic t_pushpop;
    logic [31:0] d;
    int e;
    push(200); push(201);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = 2'd0;
    @(posedge clk_i); #1;
    cs_i = 1'b0; rd_i = 1'b0;
    wr_en_i = 1'b1; wr_data_i = wv(202);
    @(negedge clk_i);
    check("R9 head during push", rdata_o, wv(200)[31:0]);
    @(posedge clk_i); #1 wr_en_i = 1'b0;
    bus_read(2'd1, d); check("R9 level unchanged", d, 32'h8000_0002);
    burst(2, 201, e); check("R9 order kept", 32'(e), 32'd0);
  endtask

  initial begin
    t_reset;
    t_basic;
    t_empty;
    t_thr;
    t_full;
    t_pushpop;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule